// File: doc/BRIEF.md
# Configurable GPIO Interrupt Detector

This block watches eight sampled GPIO input lines and turns selected pin activity into one interrupt request. Every pin has its own configuration: it can react to a level or to an edge. An edge pin can react to a single edge or to any change. A polarity bit picks which edge or which level counts. Each detected event sets a bit in a raw status register. That bit stays set until software clears it. A mask register decides which of those bits reach the interrupt output.

Software uses a small register bus with a 3-bit word index. It writes the configuration, reads the raw and masked status, and clears status bits by writing ones to a dedicated clear index. Edge detection compares the sampled pin value with the value registered one clock earlier. Edges are recognised only on pins whose direction bit marks them as inputs.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every configuration register and the raw status read as 0 and `irq_o` is low.
- R2: For a pin whose mode bit (index 0) is 0 and whose any-edge bit (index 1) is 0, a change of the sampled pin sets its raw status bit one clock later only when the new value equals its polarity bit (index 2): 1 selects rising, 0 selects falling. The opposite edge sets nothing.
- R3: For an edge-mode pin whose any-edge bit is 1, both rising and falling changes set its raw status bit.
- R4: For a pin whose mode bit is 1 (level), the raw status bit is set on every clock in which the sampled pin equals its polarity bit, whatever its direction bit.
- R5: A pin whose direction bit is 1 (output) generates no edge event. Its raw status stays unchanged.
- R6: Raw status bits are sticky. A write to index 6 clears exactly the raw bits whose write-data bit is 1 and leaves the others set.
- R7: When an event and a clear hit the same bit in the same clock, the bit stays set.
- R8: Index 5 reads raw status AND mask (mask at index 3). `irq_o` is high exactly when that value is nonzero.
- R9: Indices 0 to 3 read back the last value written. Index 4 reads raw status. Index 6 and index 7 read 0. Writes to indices 4, 5 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational from `reg_addr`) |
| pin_data | input | 8 | Sampled, already synchronised pin values |
| pin_dir | input | 8 | Direction per pin, 1 = output |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clear that lands in the same clock as a fresh event on the same bit. The clear happens on the bus, the event comes from the pins, and the two must coincide on one edge while the pin's mode makes that bit fire. Directed steps set this up twice. One case uses a level pin that keeps firing while its clear is written. The other drives a pin edge in the same cycle as the clear write. A long seeded random run then mixes pin toggles, direction changes, configuration writes and clears, so these collisions also occur with unplanned mode combinations. A bench model predicts every result.

// File: rtl/gid_pkg.sv
package gid_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] IDX_MODE   = 3'd0;
  localparam logic [ADDR_W-1:0] IDX_ANYEDG = 3'd1;
  localparam logic [ADDR_W-1:0] IDX_POL    = 3'd2;
  localparam logic [ADDR_W-1:0] IDX_MASK   = 3'd3;
  localparam logic [ADDR_W-1:0] IDX_RAW    = 3'd4;
  localparam logic [ADDR_W-1:0] IDX_MSKD   = 3'd5;
  localparam logic [ADDR_W-1:0] IDX_CLR    = 3'd6;

  // Edge event for one pin: input pin, edge mode, value changed, and either
  // any-edge is selected or the new value matches the polarity.
  function automatic logic edge_bit_hit(input logic cur, input logic prev,
                                        input logic is_out, input logic lvl_mode,
                                        input logic any_edge, input logic pol);
    logic changed;
    changed = (cur ^ prev) & ~is_out;
    return changed & ~lvl_mode & (any_edge | ~(cur ^ pol));
  endfunction

  // Level event for one pin: level mode and value matches the polarity.
  function automatic logic level_bit_hit(input logic cur, input logic lvl_mode,
                                         input logic pol);
    return lvl_mode & ~(cur ^ pol);
  endfunction
endpackage

// File: rtl/gid_regs.sv
module gid_regs
  import gid_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  input  logic [NPINS-1:0]  raw_i,
  output logic [NPINS-1:0]  mode_o,
  output logic [NPINS-1:0]  anyedge_o,
  output logic [NPINS-1:0]  pol_o,
  output logic [NPINS-1:0]  mask_o,
  output logic [NPINS-1:0]  clr_o,
  output logic [NPINS-1:0]  rdata_o
);
  logic wr_mode, wr_any, wr_pol, wr_mask;

  assign wr_mode = we && (addr == IDX_MODE);
  assign wr_any  = we && (addr == IDX_ANYEDG);
  assign wr_pol  = we && (addr == IDX_POL);
  assign wr_mask = we && (addr == IDX_MASK);
  assign clr_o   = (we && (addr == IDX_CLR)) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o    <= '0;
      anyedge_o <= '0;
      pol_o     <= '0;
      mask_o    <= '0;
    end else begin
      if (wr_mode) mode_o    <= wdata;
      if (wr_any)  anyedge_o <= wdata;
      if (wr_pol)  pol_o     <= wdata;
      if (wr_mask) mask_o    <= wdata;
    end
  end

  always_comb begin
    unique case (addr)
      IDX_MODE:   rdata_o = mode_o;
      IDX_ANYEDG: rdata_o = anyedge_o;
      IDX_POL:    rdata_o = pol_o;
      IDX_MASK:   rdata_o = mask_o;
      IDX_RAW:    rdata_o = raw_i;
      IDX_MSKD:   rdata_o = raw_i & mask_o;
      default:    rdata_o = '0;
    endcase
  end

  // R9: a mode write is visible on the next cycle
  assert_mode_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_mode) |-> (mode_o == $past(wdata)));
  // R9: the mask register only moves on a mask write
  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_mask) |-> $stable(mask_o));
endmodule

// File: rtl/gid_detect.sv
module gid_detect
  import gid_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] mode,
  input  logic [NPINS-1:0] anyedge,
  input  logic [NPINS-1:0] pol,
  output logic [NPINS-1:0] edge_hit_o,
  output logic [NPINS-1:0] level_hit_o,
  output logic [NPINS-1:0] hit_o
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin;
  end

  for (genvar b = 0; b < NPINS; b++) begin : g_pin
    assign edge_hit_o[b]  = edge_bit_hit(pin[b], prev_q[b], dir[b], mode[b],
                                         anyedge[b], pol[b]);
    assign level_hit_o[b] = level_bit_hit(pin[b], mode[b], pol[b]);
  end

  assign hit_o = edge_hit_o | level_hit_o;

  // R5: a pin held as output never yields an edge event
  assert_out_pin_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_hit_o & dir) == '0));
  // R2: an edge event needs a pin that differs from last cycle's sample
  assert_edge_needs_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_hit_o & ~(pin ^ prev_q)) == '0));
endmodule

// File: rtl/gid_status.sv
module gid_status #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] hit,
  input  logic [NPINS-1:0] clr,
  input  logic [NPINS-1:0] mask,
  output logic [NPINS-1:0] raw_o,
  output logic             irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_o <= '0;
    else        raw_o <= (raw_o & ~clr) | hit;
  end

  assign irq_o = |(raw_o & mask);

  // R1: first cycle after reset shows empty status and no request
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> ((raw_o == '0) && !irq_o));
  // R6: a set bit only drops when a clear addressed it
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(raw_o) & ~$past(clr) & ~raw_o) == '0));
  // R7: every event is latched, even against a same-cycle clear
  assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((raw_o & $past(hit)) == $past(hit)));
  // R2: a bit is never set without an event the cycle before
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(raw_o) & raw_o & ~$past(hit)) == '0));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gid_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NPINS-1:0]  reg_wdata,
  output logic [NPINS-1:0]  reg_rdata,
  input  logic [NPINS-1:0]  pin_data,
  input  logic [NPINS-1:0]  pin_dir,
  output logic              irq_o
);
  logic [NPINS-1:0] mode, anyedge, pol, mask, clr, raw;
  logic [NPINS-1:0] edge_hit, level_hit, hit;

  gid_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .raw_i(raw), .mode_o(mode), .anyedge_o(anyedge), .pol_o(pol),
    .mask_o(mask), .clr_o(clr), .rdata_o(reg_rdata)
  );

  gid_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .pin(pin_data), .dir(pin_dir), .mode(mode),
    .anyedge(anyedge), .pol(pol), .edge_hit_o(edge_hit),
    .level_hit_o(level_hit), .hit_o(hit)
  );

  gid_status #(.NPINS(NPINS)) u_status (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr(clr), .mask(mask),
    .raw_o(raw), .irq_o(irq_o)
  );

  // R8: with no request pending, the masked-status readout must be empty
  assert_irq_vs_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr == IDX_MSKD) && !irq_o) |-> (reg_rdata == '0));
  // R4: a level pin matching its polarity is pending on the next cycle
  assert_level_latched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|level_hit) |=> ((raw & $past(level_hit)) == $past(level_hit)));
endmodule

// File: tb/gpio_irq_detect_bench.sv
module gpio_irq_detect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [2:0] reg_addr = '0;
  logic [N-1:0] reg_wdata = '0, pin_data = '0, pin_dir = '0;
  logic [N-1:0] reg_rdata;
  logic irq_o;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [N-1:0] pin_v = '0, dir_v = '0;
  logic [N-1:0] m_mode = '0, m_any = '0, m_pol = '0, m_mask = '0, m_raw = '0, m_prev = '0;

  gpio_irq_detect #(.NPINS(N)) u_gpio_irq_detect (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_data(pin_data),
    .pin_dir(pin_dir), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Event vector restated per pin from the requirements
  function automatic logic [N-1:0] exp_events(input logic [N-1:0] cur, input logic [N-1:0] old,
                                              input logic [N-1:0] dir);
    logic [N-1:0] ev = '0;
    for (int i = 0; i < N; i++) begin
      if (m_mode[i]) ev[i] = (cur[i] == m_pol[i]);
      else if (!dir[i] && cur[i] != old[i]) ev[i] = m_any[i] || (cur[i] == m_pol[i]);
    end
    return ev;
  endfunction

  task automatic chk(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic cyc(input bit w, input logic [2:0] a, input logic [N-1:0] d);
    logic [N-1:0] ev, clr;
    reg_we = w; reg_addr = a; reg_wdata = d; pin_data = pin_v; pin_dir = dir_v;
    @(posedge clk);
    ev  = exp_events(pin_v, m_prev, dir_v);
    clr = (w && a == 3'd6) ? d : '0;
    m_raw  = (m_raw & ~clr) | ev;
    m_prev = pin_v;
    if (w) begin
      case (a)
        3'd0: m_mode = d;
        3'd1: m_any  = d;
        3'd2: m_pol  = d;
        3'd3: m_mask = d;
        default: ;
      endcase
    end
    #1;
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic chk_status(input string req);
    logic [N-1:0] v;
    rd(3'd4, v); chk(req, v, m_raw);
    rd(3'd5, v); chk(req, v, m_raw & m_mask);
    chk(req, {7'd0, irq_o}, {7'd0, |(m_raw & m_mask)});
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], v); chk("R1", v, 8'h00);
    end
    chk("R1", {7'd0, irq_o}, 8'h00);

    // R9: readback of configuration registers
    cyc(1, 3'd0, 8'hA5); cyc(1, 3'd1, 8'h3C); cyc(1, 3'd2, 8'h0F); cyc(1, 3'd3, 8'hF0);
    rd(3'd0, v); chk("R9", v, 8'hA5);
    rd(3'd1, v); chk("R9", v, 8'h3C);
    rd(3'd2, v); chk("R9", v, 8'h0F);
    rd(3'd3, v); chk("R9", v, 8'hF0);
    rd(3'd6, v); chk("R9", v, 8'h00);
    rd(3'd7, v); chk("R9", v, 8'h00);
    cyc(1, 3'd0, 8'h00); cyc(1, 3'd1, 8'h00); cyc(1, 3'd2, 8'h00); cyc(1, 3'd3, 8'h00);
    cyc(1, 3'd6, 8'hFF);
    cyc(1, 3'd4, 8'hFF); cyc(1, 3'd7, 8'hFF);
    rd(3'd4, v); chk("R9", v, 8'h00);
    rd(3'd3, v); chk("R9", v, 8'h00);

    // R2: single edge, pin0 rising, pin1 falling
    cyc(1, 3'd2, 8'h01); cyc(1, 3'd3, 8'hFF);
    pin_v = 8'h02; cyc(0, 3'd0, 8'h00);
    rd(3'd4, v); chk("R2", v, 8'h00);
    chk("R2", {7'd0, irq_o}, 8'h00);
    pin_v = 8'h01; cyc(0, 3'd0, 8'h00);
    rd(3'd4, v); chk("R2", v, 8'h03);
    chk("R8", {7'd0, irq_o}, 8'h01);
    cyc(1, 3'd6, 8'hFF);
    rd(3'd4, v); chk("R6", v, 8'h00);

    // R3: any edge on pin2
    cyc(1, 3'd1, 8'h04);
    pin_v = 8'h05; cyc(0, 3'd0, 8'h00);
    rd(3'd4, v); chk("R3", v, 8'h04);
    cyc(1, 3'd6, 8'h04);
    pin_v = 8'h01; cyc(0, 3'd0, 8'h00);
    rd(3'd4, v); chk("R3", v, 8'h04);
    cyc(1, 3'd6, 8'hFF);

    // R5: output pin toggles give no event
    dir_v = 8'h04; pin_v = 8'h05; cyc(0, 3'd0, 8'h00);
    rd(3'd4, v); chk("R5", v, 8'h00);
    dir_v = 8'h00; cyc(0, 3'd0, 8'h00);
    rd(3'd4, v); chk("R5", v, 8'h00);

    // R4: level-low on pin3, and R7 with a clear during the level
    cyc(1, 3'd0, 8'h08);
    cyc(0, 3'd0, 8'h00);
    rd(3'd4, v); chk("R4", v, 8'h08);
    cyc(1, 3'd6, 8'h08);
    rd(3'd4, v); chk("R7", v, 8'h08);
    pin_v = 8'h0D; cyc(0, 3'd0, 8'h00);
    cyc(1, 3'd6, 8'h08);
    rd(3'd4, v); chk("R4", v, 8'h00);
    dir_v = 8'h08; pin_v = 8'h05; cyc(0, 3'd0, 8'h00);
    rd(3'd4, v); chk("R4", v, 8'h08);
    cyc(1, 3'd0, 8'h00); dir_v = 8'h00;
    cyc(1, 3'd6, 8'hFF);

    // R6: partial clear
    cyc(1, 3'd1, 8'hFF);
    pin_v = 8'h00; cyc(0, 3'd0, 8'h00);
    rd(3'd4, v); chk("R6", v, 8'h05);
    cyc(1, 3'd6, 8'h01);
    rd(3'd4, v); chk("R6", v, 8'h04);

    // R8: masking
    cyc(1, 3'd3, 8'h01);
    rd(3'd5, v); chk("R8", v, 8'h00);
    chk("R8", {7'd0, irq_o}, 8'h00);
    cyc(1, 3'd3, 8'h04);
    rd(3'd5, v); chk("R8", v, 8'h04);
    chk("R8", {7'd0, irq_o}, 8'h01);

    // R7: edge and clear on the same bit in the same cycle
    pin_v = 8'h10; cyc(1, 3'd6, 8'h10);
    rd(3'd4, v); chk("R7", v, 8'h14);

    // Random mix against the bench model
    for (int k = 0; k < 600; k++) begin
      pin_v = $urandom; dir_v = $urandom;
      cyc(($urandom % 3) == 0, 3'($urandom % 8), 8'($urandom));
      chk_status("R2 R3 R4 R5 R6 R7 R8 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule